// File: doc/BRIEF.md
# Page write load controller

The block gathers a burst of host byte writes into a one-page buffer and then programs the page into a behavioural non-volatile array in a single internally timed cycle. There is no explicit commit command. Each accepted byte write restarts a load timer. When the timer runs out with no further write, the buffered bytes are handed to the programming phase. That phase lasts a fixed number of clock cycles and does not stop early.

An address splits into a byte offset (the low `OFFS_W` bits) and a page number (the bits above them). Every byte of one burst must carry the page number of the first byte. If a later write names a different page, the whole burst is cancelled: the buffered data is dropped, no programming takes place, and an abort flag is raised. The host observes the block through three status outputs (loading, busy, abort) and reads the array through a combinational read port. All timing is given in clock cycles by parameters.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, `loading_o`, `busy_o` and `abort_o` are 0 and every array byte reads 8'hFF.
- R2: Address bits [OFFS_W-1:0] select the byte within a page and bits [ADDR_W-1:OFFS_W] select the page. A committed byte is readable at the same address on `raddr_i`.
- R3: An accepted write restarts the load timer. A write arriving at most `LOAD_CYC` clock edges after the previous accepted write joins the same page.
- R4: When no write arrives, `busy_o` rises exactly `LOAD_CYC` clock edges after the edge that sampled the last accepted write.
- R5: `busy_o` stays high for `PROG_BYTE_CYC` cycles when exactly one distinct byte offset was loaded, and for `PROG_PAGE_CYC` cycles otherwise. The array shows the new data from the edge where `busy_o` falls.
- R6: Only the loaded offsets of the page change. All other bytes of that page and of every other page keep their contents.
- R7: A write offered while `busy_o` is high is dropped. It changes no array byte and does not start a new load.
- R8: A write whose page differs from the page of the burst cancels the burst. `abort_o` goes to 1, `loading_o` goes to 0, no programming follows, and none of the burst's bytes reach the array.
- R9: `abort_o` holds its value until the next accepted write that starts a new burst. That write clears it to 0.
- R10: When the same offset is written twice in one burst, the later data is programmed, and the burst counts as a single byte for the R5 timing.
- R11: `loading_o` is 1 from the edge of the first accepted write of a burst until the burst commits or aborts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Byte write strobe, one per cycle |
| addr_i | input | ADDR_W | Write address: page number and byte offset |
| wdata_i | input | 8 | Write data byte |
| raddr_i | input | ADDR_W | Array read address |
| rdata_o | output | 8 | Array byte at `raddr_i`, combinational |
| loading_o | output | 1 | Load timer running, burst in progress |
| busy_o | output | 1 | Programming phase in progress |
| abort_o | output | 1 | Last burst was cancelled by a page change |

## Verification
A write sampled at edge k shows on `loading_o` and `abort_o` right after that edge. `busy_o` rises after edge k+LOAD_CYC. It falls, and the array shows the new data, `PROG_BYTE_CYC` or `PROG_PAGE_CYC` edges later. The bench drives every input and samples every output on falling edges. It finds the rise and the fall of `busy_o` by counting falling edges, so a latency or duration that is off by one cycle shows as a count mismatch. The gap cases are placed on exactly `LOAD_CYC` edges (the write joins) and on `LOAD_CYC`+1 edges (the write is dropped), which checks the timer boundary on both sides.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    PLC_IDLE = 2'd0,
    PLC_LOAD = 2'd1,
    PLC_PROG = 2'd2
  } plc_state_e;

  typedef logic [7:0] plc_byte_t;
endpackage

// File: rtl/plc_down_timer.sv
module plc_down_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/plc_page_buf.sv
module plc_page_buf #(
  parameter int unsigned OFFS_W = 7,
  localparam int unsigned PAGE_BYTES = 1 << OFFS_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [OFFS_W-1:0]       offs_i,
  input  logic [7:0]              data_i,
  output logic [PAGE_BYTES-1:0]   valid_o,
  output logic [PAGE_BYTES*8-1:0] data_o
);
  for (genvar o = 0; o < PAGE_BYTES; o++) begin : g_slot
    logic hit;
    logic valid_q;
    logic [7:0] data_q;

    assign hit = wr_i && (offs_i == OFFS_W'(o));

    // clear and write in one cycle leave only the new byte valid
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        data_q  <= 8'h00;
      end else begin
        valid_q <= hit | (valid_q & ~clr_i);
        if (hit) data_q <= data_i;
      end
    end

    assign valid_o[o]        = valid_q;
    assign data_o[o*8 +: 8]  = data_q;
  end
endmodule

// File: rtl/plc_array.sv
module plc_array #(
  parameter int unsigned OFFS_W = 7,
  parameter int unsigned PAGE_W = 3,
  localparam int unsigned ADDR_W     = OFFS_W + PAGE_W,
  localparam int unsigned PAGE_BYTES = 1 << OFFS_W,
  localparam int unsigned NUM_PAGES  = 1 << PAGE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [PAGE_BYTES-1:0]   valid_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [7:0]              rdata_o
);
  logic [PAGE_W-1:0]       rd_page;
  logic [OFFS_W-1:0]       rd_offs;
  logic [PAGE_BYTES*8-1:0] rd_row;

  assign rd_page = raddr_i[ADDR_W-1:OFFS_W];
  assign rd_offs = raddr_i[OFFS_W-1:0];

  // one column per byte offset, each holding that offset for every page
  for (genvar o = 0; o < PAGE_BYTES; o++) begin : g_col
    logic [7:0] col_q [NUM_PAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int p = 0; p < NUM_PAGES; p++) col_q[p] <= 8'hFF;
      end else if (commit_i && valid_i[o]) begin
        col_q[page_i] <= data_i[o*8 +: 8];
      end
    end

    assign rd_row[o*8 +: 8] = col_q[rd_page];
  end

  assign rdata_o = rd_row[rd_offs*8 +: 8];
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import plc_pkg::*;
#(
  parameter int unsigned OFFS_W        = 7,
  parameter int unsigned PAGE_W        = 3,
  parameter int unsigned LOAD_CYC      = 8,
  parameter int unsigned PROG_BYTE_CYC = 20,
  parameter int unsigned PROG_PAGE_CYC = 40,
  localparam int unsigned ADDR_W     = OFFS_W + PAGE_W,
  localparam int unsigned PAGE_BYTES = 1 << OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o,
  output logic              loading_o,
  output logic              busy_o,
  output logic              abort_o
);
  localparam int unsigned PROG_MAX = (PROG_PAGE_CYC > PROG_BYTE_CYC) ? PROG_PAGE_CYC : PROG_BYTE_CYC;
  localparam int unsigned LOAD_W   = $clog2(LOAD_CYC);
  localparam int unsigned PROG_W   = $clog2(PROG_MAX);

  plc_state_e state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic              abort_q;

  logic [PAGE_W-1:0] wr_page;
  logic [OFFS_W-1:0] wr_offs;
  logic              page_hit;

  logic buf_clr, buf_wr, ld_restart, prog_load, commit;
  logic abort_set, abort_clr, page_ld;
  logic ld_zero, prog_zero;

  logic [PAGE_BYTES-1:0]   buf_valid;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PROG_W-1:0]       prog_val;

  assign wr_page  = addr_i[ADDR_W-1:OFFS_W];
  assign wr_offs  = addr_i[OFFS_W-1:0];
  assign page_hit = (wr_page == page_q);

  // programming length depends on how many distinct offsets were loaded
  assign prog_val = $onehot(buf_valid) ? PROG_W'(PROG_BYTE_CYC - 1)
                                       : PROG_W'(PROG_PAGE_CYC - 1);

  always_comb begin
    state_d    = state_q;
    buf_clr    = 1'b0;
    buf_wr     = 1'b0;
    ld_restart = 1'b0;
    prog_load  = 1'b0;
    commit     = 1'b0;
    abort_set  = 1'b0;
    abort_clr  = 1'b0;
    page_ld    = 1'b0;
    unique case (state_q)
      PLC_IDLE: begin
        if (wr_i) begin
          buf_clr    = 1'b1;
          buf_wr     = 1'b1;
          ld_restart = 1'b1;
          page_ld    = 1'b1;
          abort_clr  = 1'b1;
          state_d    = PLC_LOAD;
        end
      end
      PLC_LOAD: begin
        // a write on the expiry cycle still joins the page
        if (wr_i) begin
          if (page_hit) begin
            buf_wr     = 1'b1;
            ld_restart = 1'b1;
          end else begin
            buf_clr   = 1'b1;
            abort_set = 1'b1;
            state_d   = PLC_IDLE;
          end
        end else if (ld_zero) begin
          prog_load = 1'b1;
          state_d   = PLC_PROG;
        end
      end
      PLC_PROG: begin
        if (prog_zero) begin
          commit  = 1'b1;
          buf_clr = 1'b1;
          state_d = PLC_IDLE;
        end
      end
      default: state_d = PLC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PLC_IDLE;
      page_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (page_ld)        page_q  <= wr_page;
      if (abort_set)      abort_q <= 1'b1;
      else if (abort_clr) abort_q <= 1'b0;
    end
  end

  plc_down_timer #(.W(LOAD_W)) u_load_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_restart),
    .load_val_i (LOAD_W'(LOAD_CYC - 1)),
    .run_i      (state_q == PLC_LOAD),
    .zero_o     (ld_zero)
  );

  plc_down_timer #(.W(PROG_W)) u_prog_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (prog_load),
    .load_val_i (prog_val),
    .run_i      (state_q == PLC_PROG),
    .zero_o     (prog_zero)
  );

  plc_page_buf #(.OFFS_W(OFFS_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (buf_clr),
    .wr_i    (buf_wr),
    .offs_i  (wr_offs),
    .data_i  (wdata_i),
    .valid_o (buf_valid),
    .data_o  (buf_data)
  );

  plc_array #(.OFFS_W(OFFS_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .page_i   (page_q),
    .valid_i  (buf_valid),
    .data_i   (buf_data),
    .raddr_i  (raddr_i),
    .rdata_o  (rdata_o)
  );

  assign loading_o = (state_q == PLC_LOAD);
  assign busy_o    = (state_q == PLC_PROG);
  assign abort_o   = abort_q;
endmodule

// File: rtl/plc_chk.sv
module plc_chk #(
  parameter int unsigned PROG_BYTE_CYC = 20,
  parameter int unsigned PROG_PAGE_CYC = 40
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic loading_o,
  input logic busy_o,
  input logic abort_o
);
  localparam int unsigned CW = $clog2(PROG_PAGE_CYC + PROG_BYTE_CYC + 2);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= '0;
    else if (busy_o) busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  // R11
  busy_load_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && loading_o));

  // R4
  busy_from_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(loading_o));

  // R5
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len == CW'(PROG_BYTE_CYC) || busy_len == CW'(PROG_PAGE_CYC)));

  // R7
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_i) |=> !loading_o);

  // R8
  abort_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> ($past(wr_i) && !loading_o));

  // R9
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(abort_o) |-> ($past(wr_i) && loading_o));

  // R11
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loading_o) |-> $past(wr_i));
endmodule

bind page_load_ctrl plc_chk #(
  .PROG_BYTE_CYC(PROG_BYTE_CYC),
  .PROG_PAGE_CYC(PROG_PAGE_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .loading_o (loading_o),
  .busy_o    (busy_o),
  .abort_o   (abort_o)
);

// File: tb/page_load_ctrl_tb.sv
module page_load_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFFS_W = 7;
  localparam int PAGE_W = 3;
  localparam int ADDR_W = OFFS_W + PAGE_W;
  localparam int PB     = 1 << OFFS_W;
  localparam int T      = 8;
  localparam int DB     = 20;
  localparam int DP     = 40;

  // {page, start offset, byte count, data seed}
  localparam logic [31:0] VEC [6] = '{
    {8'd0, 8'd10,  8'd1,   8'h3C},
    {8'd1, 8'd0,   8'd4,   8'hA0},
    {8'd2, 8'd120, 8'd8,   8'h11},
    {8'd7, 8'd0,   8'd128, 8'h00},
    {8'd3, 8'd64,  8'd2,   8'hF0},
    {8'd0, 8'd11,  8'd1,   8'h5A}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [ADDR_W-1:0] raddr_i = '0;
  logic [7:0] rdata_o;
  logic loading_o, busy_o, abort_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_mem [1 << ADDR_W];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_load_ctrl #(
    .OFFS_W(OFFS_W), .PAGE_W(PAGE_W), .LOAD_CYC(T),
    .PROG_BYTE_CYC(DB), .PROG_PAGE_CYC(DP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .raddr_i(raddr_i), .rdata_o(rdata_o),
    .loading_o(loading_o), .busy_o(busy_o), .abort_o(abort_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write sampled at the posedge following the next negedge; returns on the negedge after it
  task automatic wr_byte(input int pg, input int off, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1;
    addr_i = {PAGE_W'(pg), OFFS_W'(off)};
    wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic check_page(input int pg, input string req);
    int bad_off = -1;
    logic [7:0] act = 0, exp = 0;
    for (int o = 0; o < PB; o++) begin
      raddr_i = {PAGE_W'(pg), OFFS_W'(o)};
      #1;
      if (bad_off < 0 && rdata_o !== exp_mem[pg*PB + o]) begin
        bad_off = o; act = rdata_o; exp = exp_mem[pg*PB + o];
      end
    end
    chk(bad_off < 0, req, act, exp);
  endtask

  task automatic wait_commit(input int exp_lat, input int exp_dur, input string req_l, input string req_d);
    int lat = 0;
    int dur = 0;
    while (!busy_o && lat < 1000) begin @(negedge clk); lat++; end
    chk(lat == exp_lat, req_l, lat, exp_lat);
    while (busy_o && dur < 1000) begin @(negedge clk); dur++; end
    chk(dur == exp_dur, req_d, dur, exp_dur);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!loading_o && !busy_o && !abort_o, "R1 flags", {loading_o, busy_o, abort_o}, 0);
    check_page(0, "R1 erased page 0");
    check_page(7, "R1 erased page 7");

    // table walk: R2 R4 R5 R6 R11
    for (int v = 0; v < 6; v++) begin
      int pg  = VEC[v][31:24];
      int off = VEC[v][23:16];
      int n   = VEC[v][15:8];
      logic [7:0] seed = VEC[v][7:0];
      for (int i = 0; i < n; i++) wr_byte(pg, off + i, seed + 8'(i));
      chk(loading_o == 1'b1, "R11 loading after write", loading_o, 1);
      wait_commit(T, (n == 1) ? DB : DP, "R4 commit latency", "R5 busy length");
      for (int i = 0; i < n; i++) exp_mem[pg*PB + off + i] = seed + 8'(i);
      check_page(pg, "R2 R6 page contents");
    end
    check_page(0, "R6 page 0 keeps earlier byte");

    // R3 second write exactly LOAD_CYC edges later joins
    wr_byte(4, 1, 8'h11);
    repeat (T-2) @(negedge clk);
    wr_byte(4, 2, 8'h22);
    wait_commit(T, DP, "R3 joined latency", "R3 joined two bytes");
    exp_mem[4*PB + 1] = 8'h11; exp_mem[4*PB + 2] = 8'h22;
    check_page(4, "R3 joined contents");

    // R7 write one edge too late lands while busy and is dropped
    wr_byte(5, 1, 8'h33);
    repeat (T-1) @(negedge clk);
    wr_byte(5, 2, 8'h44);
    chk(busy_o && !loading_o, "R7 late write not loaded", {busy_o, loading_o}, 2);
    wait_commit(0, DB-1, "R7 still busy", "R7 byte length unchanged");
    exp_mem[5*PB + 1] = 8'h33;
    check_page(5, "R7 dropped byte absent");

    // R8 page change cancels burst
    wr_byte(6, 0, 8'h77);
    wr_byte(1, 5, 8'h99);
    chk(abort_o && !loading_o, "R8 abort raised", {abort_o, loading_o}, 2);
    begin
      bit saw_busy = 0;
      for (int i = 0; i < T + 4; i++) begin @(negedge clk); saw_busy |= busy_o; end
      chk(!saw_busy, "R8 no programming", saw_busy, 0);
    end
    chk(abort_o == 1'b1, "R9 abort held", abort_o, 1);
    check_page(6, "R8 page 6 untouched");
    check_page(1, "R8 page 1 untouched");

    // R9 next burst clears abort
    wr_byte(6, 3, 8'h12);
    chk(!abort_o && loading_o, "R9 abort cleared", {abort_o, loading_o}, 1);
    wait_commit(T, DB, "R9 latency", "R9 length");
    exp_mem[6*PB + 3] = 8'h12;
    check_page(6, "R9 contents");

    // R10 same offset twice
    wr_byte(2, 0, 8'h01);
    wr_byte(2, 0, 8'h02);
    wait_commit(T, DB, "R10 latency", "R10 single byte length");
    exp_mem[2*PB + 0] = 8'h02;
    check_page(2, "R10 later data wins");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule